// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block decides where incoming Ethernet frames are stored in a byte-wide packet memory that is split into 256-byte pages. A circular receive ring occupies the pages from a programmable first page up to, but not including, a programmable limit page. Each frame starts on a page boundary. Its bytes begin four bytes into the page, and the block fills that 4-byte slot afterwards with a header. The header gives the page where the following frame will begin, a status byte and the stored byte count.

The block tracks a write pointer (the page the next frame will use) and a boundary page that the host owns. When the host has consumed a frame, it moves the boundary to one page below the header's link page, or to the limit page minus one when that would fall below the first page. The block never advances a frame into the boundary page. In that case it raises an overwrite flag and leaves the write pointer where it was. Frames of illegal length and frames flagged bad by the source are dropped with a receive-error flag.

Status flags are cleared by writing ones. An interrupt line is raised for each flag enabled in a mask. A start/stop command gates reception, and a stopped indication is visible in the status register.

Top module: `rxring_top`

## Requirements
- R1: After reset the block is stopped, the status register reads 0x80, all page registers and the mask read 0, `irq_o` is low and no memory write occurs.
- R2: Register 0 writes start with bit 0 and stop with bit 1, and stop wins when both are set. It reads back bit 0 as running. Status bit 7 reads 1 while stopped and 0 while running. While stopped, frames cause no memory write, no status bit and no change of the write pointer.
- R3: The first byte of a frame is written at address writeptr·256+4 and the following bytes go to consecutive addresses. After offset 255 of page limit−1 the next byte goes to offset 0 of the first ring page. Each memory write appears on the memory port one cycle after its input beat.
- R4: On success the header is written at page writeptr, offsets 0 to 3. Offset 0 holds the link page, offset 1 holds status 0x01, offset 2 holds count[7:0] and offset 3 holds count[15:8]. The count is every byte of the frame, CRC included.
- R5: The link page is the page after the page of the frame's last byte, wrapped from limit back to the first page. The write pointer takes this value only when the frame succeeds, so the next frame starts on a fresh page.
- R6: A frame whose count is below 64 or above 1518, or whose last beat carries the error flag, sets status bit 1. It leaves the write pointer unchanged and writes no header.
- R7: A frame overflows if its starting page equals the boundary, or if any page it moves into (including the link page) equals the boundary. An overflowing frame sets status bit 2, leaves the write pointer unchanged and discards the rest of its bytes. Overflow takes priority over a length error.
- R8: A successful frame sets status bit 0 once its header is written.
- R9: Writing ones to status bits 0 to 2 clears them. `irq_o` is high exactly when a status bit among 0 to 2 is set and its mask bit (register 6, same position) is set.
- R10: Registers are at these addresses: 1 first ring page, 2 limit page, 3 boundary, 4 write pointer, 5 status, 6 mask. Each register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| rx_valid_i | input | 1 | Input byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | Frame bad, sampled with the last byte |
| rx_data_i | input | 8 | Input byte |
| mem_we_o | output | 1 | Packet memory write strobe |
| mem_addr_o | output | 16 | Packet memory byte address |
| mem_wdata_o | output | 8 | Packet memory write data |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest case to reach is an overflow caused by the page a frame would move into, rather than by its first page. The host's boundary has to sit exactly at the page after a frame's crossing point. To get there, the stimulus shrinks the ring to six pages and sends two-page frames with no consumption, so the third frame wraps from the limit page straight into the boundary. Randomly sized frames then follow, with random consumption, and a bench ring model predicts each success, error and overflow. That phase also produces frames that wrap across the limit page.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [1:0] {WS_IDLE, WS_DATA, WS_DROP, WS_HDR} wr_state_e;

  localparam logic [2:0] RA_CMD    = 3'd0;
  localparam logic [2:0] RA_PSTART = 3'd1;
  localparam logic [2:0] RA_PSTOP  = 3'd2;
  localparam logic [2:0] RA_BNRY   = 3'd3;
  localparam logic [2:0] RA_CURR   = 3'd4;
  localparam logic [2:0] RA_ISR    = 3'd5;
  localparam logic [2:0] RA_IMR    = 3'd6;

  localparam int ST_PRX = 0;
  localparam int ST_RXE = 1;
  localparam int ST_OVW = 2;
  localparam int ST_W   = 3;

  localparam int HDR_BYTES = 4;
  localparam logic [7:0] HDR_STATUS_OK = 8'h01;
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              running_o,
  output logic [PAGE_W-1:0] pstart_o,
  output logic [PAGE_W-1:0] pstop_o,
  output logic [PAGE_W-1:0] bnry_o,
  output logic [PAGE_W-1:0] curr_o,
  input  logic              set_prx_i,
  input  logic              set_rxe_i,
  input  logic              set_ovw_i,
  input  logic              curr_we_i,
  input  logic [PAGE_W-1:0] curr_nxt_i,
  output logic              irq_o
);
  logic              stopped_q;
  logic [PAGE_W-1:0] pstart_q, pstop_q, bnry_q, curr_q;
  logic [ST_W-1:0]   isr_q, imr_q, st_set, st_clr;

  logic host_curr_we;
  assign host_curr_we = reg_we_i && (reg_addr_i == RA_CURR);

  always_comb begin
    st_set = '0;
    st_set[ST_PRX] = set_prx_i;
    st_set[ST_RXE] = set_rxe_i;
    st_set[ST_OVW] = set_ovw_i;
    st_clr = (reg_we_i && reg_addr_i == RA_ISR) ? reg_wdata_i[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_q <= 1'b1;
      pstart_q  <= '0;
      pstop_q   <= '0;
      bnry_q    <= '0;
      imr_q     <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CMD: begin
          if (reg_wdata_i[1])      stopped_q <= 1'b1;
          else if (reg_wdata_i[0]) stopped_q <= 1'b0;
        end
        RA_PSTART: pstart_q <= reg_wdata_i[PAGE_W-1:0];
        RA_PSTOP:  pstop_q  <= reg_wdata_i[PAGE_W-1:0];
        RA_BNRY:   bnry_q   <= reg_wdata_i[PAGE_W-1:0];
        RA_IMR:    imr_q    <= reg_wdata_i[ST_W-1:0];
        default: ;
      endcase
    end
  end

  // host write wins over a commit in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           curr_q <= '0;
    else if (host_curr_we) curr_q <= reg_wdata_i[PAGE_W-1:0];
    else if (curr_we_i)    curr_q <= curr_nxt_i;
  end

  // a set beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~st_clr) | st_set;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CMD:    reg_rdata_o = {6'd0, stopped_q, ~stopped_q};
      RA_PSTART: reg_rdata_o = 8'(pstart_q);
      RA_PSTOP:  reg_rdata_o = 8'(pstop_q);
      RA_BNRY:   reg_rdata_o = 8'(bnry_q);
      RA_CURR:   reg_rdata_o = 8'(curr_q);
      RA_ISR:    reg_rdata_o = {stopped_q, 4'd0, isr_q};
      RA_IMR:    reg_rdata_o = 8'(imr_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign running_o = ~stopped_q;
  assign pstart_o  = pstart_q;
  assign pstop_o   = pstop_q;
  assign bnry_o    = bnry_q;
  assign curr_o    = curr_q;
  assign irq_o     = |(isr_q & imr_q);

  // R7: an overflow never moves the write pointer
  a_r7_ovw_curr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_ovw_i && !host_curr_we) |=> $stable(curr_q));
  // R8: a commit always leaves the received flag set
  a_r8_prx_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    curr_we_i |=> isr_q[ST_PRX]);
  // R9: a clear with no concurrent set drops the flag
  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_ISR && reg_wdata_i[ST_RXE] && !set_rxe_i) |=> !isr_q[ST_RXE]);
endmodule

// File: rtl/rxring_wr.sv
module rxring_wr
  import rxring_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              running_i,
  input  logic [PAGE_W-1:0] pstart_i,
  input  logic [PAGE_W-1:0] pstop_i,
  input  logic [PAGE_W-1:0] bnry_i,
  input  logic [PAGE_W-1:0] curr_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_err_i,
  input  logic [7:0]        rx_data_i,
  output logic              mem_we_o,
  output logic [PAGE_W+7:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              set_prx_o,
  output logic              set_rxe_o,
  output logic              set_ovw_o,
  output logic              curr_we_o,
  output logic [PAGE_W-1:0] curr_nxt_o
);
  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam int ADDR_W = PAGE_W + 8;
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);
  localparam logic [7:0] DATA_OFF = 8'(HDR_BYTES);

  wr_state_e         state_q, state_d;
  logic [PAGE_W-1:0] wp_q, sp_q, np_q;
  logic [7:0]        off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        hidx_q;

  logic              first, beat, crossed, ovf, len_bad, hdr_last;
  logic [PAGE_W-1:0] cur_pg, pg_inc;
  logic [7:0]        cur_off, hdr_byte;
  logic [CNT_W-1:0]  cnt_n;
  logic [15:0]       cnt16;

  function automatic logic [PAGE_W-1:0] ring_next(input logic [PAGE_W-1:0] p,
                                                  input logic [PAGE_W-1:0] lo,
                                                  input logic [PAGE_W-1:0] hi);
    logic [PAGE_W-1:0] q;
    q = p + 1'b1;
    return (q == hi) ? lo : q;
  endfunction

  assign first   = (state_q == WS_IDLE);
  assign beat    = running_i && rx_valid_i &&
                   ((first && rx_sof_i) || state_q == WS_DATA);
  assign cur_pg  = first ? curr_i : wp_q;
  assign cur_off = first ? DATA_OFF : off_q;
  assign cnt_n   = first ? CNT_W'(1) : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
  assign pg_inc  = ring_next(cur_pg, pstart_i, pstop_i);
  assign crossed = &cur_off;
  // the page being entered (mid-frame) or the link page (at the end) must not be the boundary
  assign ovf     = (first && curr_i == bnry_i) ||
                   ((pg_inc == bnry_i) && (crossed || rx_eof_i));
  assign len_bad = rx_err_i || (cnt_n < MIN_C) || (cnt_n > MAX_C);
  assign hdr_last = (state_q == WS_HDR) && (hidx_q == 2'd3);
  assign cnt16   = 16'(cnt_q);

  always_comb begin
    case (hidx_q)
      2'd0:    hdr_byte = 8'(np_q);
      2'd1:    hdr_byte = HDR_STATUS_OK;
      2'd2:    hdr_byte = cnt16[7:0];
      default: hdr_byte = cnt16[15:8];
    endcase
  end

  always_comb begin
    state_d   = state_q;
    set_prx_o = 1'b0;
    set_rxe_o = 1'b0;
    set_ovw_o = 1'b0;
    curr_we_o = 1'b0;
    if (!running_i) begin
      state_d = WS_IDLE;
    end else begin
      case (state_q)
        WS_IDLE, WS_DATA: begin
          if (beat) begin
            if (ovf) begin
              set_ovw_o = 1'b1;
              state_d   = rx_eof_i ? WS_IDLE : WS_DROP;
            end else if (rx_eof_i) begin
              if (len_bad) begin
                set_rxe_o = 1'b1;
                state_d   = WS_IDLE;
              end else begin
                state_d = WS_HDR;
              end
            end else begin
              state_d = WS_DATA;
            end
          end
        end
        WS_DROP: if (rx_valid_i && rx_eof_i) state_d = WS_IDLE;
        WS_HDR: begin
          if (hdr_last) begin
            set_prx_o = 1'b1;
            curr_we_o = 1'b1;
            state_d   = WS_IDLE;
          end
        end
        default: state_d = WS_IDLE;
      endcase
    end
  end

  assign curr_nxt_o = np_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      wp_q    <= '0;
      sp_q    <= '0;
      np_q    <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      hidx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat) begin
        wp_q   <= crossed ? pg_inc : cur_pg;
        off_q  <= cur_off + 8'd1;
        cnt_q  <= cnt_n;
        hidx_q <= '0;
        if (first)    sp_q <= curr_i;
        if (rx_eof_i) np_q <= pg_inc;
      end else if (running_i && state_q == WS_HDR) begin
        hidx_q <= hidx_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (beat) begin
        mem_we_o    <= 1'b1;
        mem_addr_o  <= {cur_pg, cur_off};
        mem_wdata_o <= rx_data_i;
      end else if (running_i && state_q == WS_HDR) begin
        mem_we_o    <= 1'b1;
        mem_addr_o  <= ADDR_W'({sp_q, 6'd0, hidx_q});
        mem_wdata_o <= hdr_byte;
      end
    end
  end

  // R2: no memory traffic the cycle after a stopped cycle
  a_r2_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |=> !mem_we_o);
  // R5: a committed link page lies inside a sane ring
  a_r5_link_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (curr_we_o && pstart_i < pstop_i && sp_q >= pstart_i && sp_q < pstop_i)
      |-> (curr_nxt_o >= pstart_i && curr_nxt_o < pstop_i));
  // R6 R7 R8: each frame has one outcome
  a_r6_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_prx_o, set_rxe_o, set_ovw_o}));
  // R4: header bytes go to the frame's start page
  a_r4_hdr_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && state_q == WS_HDR) |=> (mem_we_o && mem_addr_o[ADDR_W-1:8] == sp_q));
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_err_i,
  input  logic [7:0]        rx_data_i,
  output logic              mem_we_o,
  output logic [PAGE_W+7:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              irq_o
);
  logic              running, set_prx, set_rxe, set_ovw, curr_we;
  logic [PAGE_W-1:0] pstart, pstop, bnry, curr, curr_nxt;

  rxring_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .running_o(running), .pstart_o(pstart), .pstop_o(pstop),
    .bnry_o(bnry), .curr_o(curr),
    .set_prx_i(set_prx), .set_rxe_i(set_rxe), .set_ovw_i(set_ovw),
    .curr_we_i(curr_we), .curr_nxt_i(curr_nxt), .irq_o
  );

  rxring_wr #(.PAGE_W(PAGE_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_wr (
    .clk_i, .rst_ni, .running_i(running),
    .pstart_i(pstart), .pstop_i(pstop), .bnry_i(bnry), .curr_i(curr),
    .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_err_i, .rx_data_i,
    .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .set_prx_o(set_prx), .set_rxe_o(set_rxe), .set_ovw_o(set_ovw),
    .curr_we_o(curr_we), .curr_nxt_o(curr_nxt)
  );
endmodule

// File: tb/sim_rxring_top.sv
`timescale 1ns/1ps
module sim_rxring_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        irq;

  always #2 clk = ~clk;

  rxring_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_err_i(rx_err), .rx_data_i(rx_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .irq_o(irq)
  );

  bit [7:0] mem [int];
  int nwr = 0;
  always @(posedge clk) if (mem_we) begin
    mem[int'(mem_addr)] = mem_wdata;
    nwr++;
  end

  int checks = 0, fails = 0;
  int m_start, m_stop, m_curr, m_bnry, rd_ptr;
  int q_seq[$], q_len[$], q_pg[$], q_nxt[$];
  int n_ovw = 0, n_wrap = 0, seq = 0;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=complete");
    summary();
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bval(int s, int i);
    return (s * 37 + i * 11 + (i >> 8)) & 255;
  endfunction

  function automatic int wrap(int p);
    return (p + 1 == m_stop) ? m_start : p + 1;
  endfunction

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic drive(int s, int len, bit err);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_err = err && (i == len - 1); rx_data = 8'(bval(s, i));
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // send one frame and check status / write pointer against the ring model
  task automatic frame(int len, bit err);
    int npg, p, ovf, bad, isr, cur, exp_isr;
    seq++;
    wr(3'd5, 7);
    npg = (len + 4 + 255) / 256;
    ovf = (m_curr == m_bnry);
    p = m_curr;
    for (int k = 1; k <= npg; k++) begin
      p = wrap(p);
      if (p == m_bnry) ovf = 1;
    end
    bad = err || len < 64 || len > 1518;
    drive(seq, len, err);
    rd(3'd5, isr);
    rd(3'd4, cur);
    if (ovf) begin
      exp_isr = 4; n_ovw++;
      chk("R7 overflow status", isr & 7, exp_isr);
      chk("R7 curr held on overflow", cur, m_curr);
    end else if (bad) begin
      chk("R6 length/error status", isr & 7, 2);
      chk("R6 curr held on error", cur, m_curr);
    end else begin
      chk("R8 received status", isr & 7, 1);
      chk("R5 curr advanced to link page", cur, p);
      q_seq.push_back(seq); q_len.push_back(len);
      q_pg.push_back(m_curr); q_nxt.push_back(p);
      m_curr = p;
    end
  endtask

  task automatic consume();
    int s, len, pg, nxt, bad, addr, b;
    if (q_seq.size() == 0) return;
    s = q_seq.pop_front(); len = q_len.pop_front();
    pg = q_pg.pop_front(); nxt = q_nxt.pop_front();
    chk("R4 header link byte", int'(mem[pg * 256 + 0]), nxt);
    chk("R4 header status byte", int'(mem[pg * 256 + 1]), 1);
    chk("R4 header count", int'(mem[pg * 256 + 2]) + 256 * int'(mem[pg * 256 + 3]), len);
    bad = 0;
    for (int i = 0; i < len; i++) begin
      b = pg + ((4 + i) >> 8);
      if (b >= m_stop) b = b - m_stop + m_start;
      addr = b * 256 + ((4 + i) & 255);
      if (int'(mem[addr]) != bval(s, i)) bad++;
    end
    if (pg + ((len + 3) >> 8) >= m_stop) n_wrap++;
    chk("R3 data placement", bad, 0);
    m_bnry = (nxt - 1 < m_start) ? m_stop - 1 : nxt - 1;
    wr(3'd3, m_bnry);
  endtask

  task automatic setup_ring(int s, int e);
    wr(3'd0, 2);
    m_start = s; m_stop = e; m_bnry = s; m_curr = s + 1;
    wr(3'd1, s); wr(3'd2, e); wr(3'd3, s); wr(3'd4, s + 1);
    wr(3'd5, 7);
    wr(3'd0, 1);
  endtask

  initial begin
    int d, w0, c0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(3'd5, d); chk("R1 status at reset", d, 8'h80);
    rd(3'd4, d); chk("R1 curr at reset", d, 0);
    rd(3'd6, d); chk("R1 mask at reset", d, 0);
    chk("R1 irq at reset", int'(irq), 0);
    chk("R1 no writes in reset", nwr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd0, d); chk("R2 stopped after reset", d, 2);

    // R10: register readback
    setup_ring(6, 62);
    wr(3'd6, 7);
    rd(3'd1, d); chk("R10 first page readback", d, 6);
    rd(3'd2, d); chk("R10 limit readback", d, 62);
    rd(3'd3, d); chk("R10 boundary readback", d, 6);
    rd(3'd4, d); chk("R10 curr readback", d, 7);
    rd(3'd6, d); chk("R10 mask readback", d, 7);
    rd(3'd0, d); chk("R2 running readback", d, 1);
    rd(3'd5, d); chk("R2 status bit7 low when running", d & 8'h80, 0);

    // length corners
    frame(1518, 0); consume();
    chk("R9 irq on received", int'(irq), 1);
    wr(3'd5, 7); @(negedge clk);
    chk("R9 irq clears after w1c", int'(irq), 0);
    frame(1519, 0);
    frame(63, 0);
    frame(64, 0); consume();
    frame(100, 1);
    wr(3'd6, 2);
    frame(200, 0); consume();
    chk("R9 masked flag keeps irq low", int'(irq), 0);
    wr(3'd6, 7);

    // R2: stopped block ignores frames
    wr(3'd0, 3);
    rd(3'd5, d); chk("R2 status bit7 when stopped", d & 8'h80, 8'h80);
    wr(3'd5, 7);
    w0 = nwr;
    rd(3'd4, c0);
    seq++; drive(seq, 80, 0);
    chk("R2 no writes while stopped", nwr - w0, 0);
    rd(3'd4, d); chk("R2 curr unchanged while stopped", d, c0);
    rd(3'd5, d); chk("R2 no flags while stopped", d & 7, 0);
    wr(3'd0, 1);
    rd(3'd5, d); chk("R2 status bit7 clear after start", d & 8'h80, 0);

    // small ring: directed overflow on a page crossing, then random traffic
    setup_ring(6, 12);
    frame(300, 0);
    frame(300, 0);
    frame(300, 0);
    chk("R7 crossing overflow seen", n_ovw, 1);
    consume(); consume();
    for (int n = 0; n < 60; n++) begin
      int len;
      len = ($urandom % 8 == 0) ? int'($urandom_range(20, 63)) : int'($urandom_range(64, 520));
      frame(len, 0);
      if ($urandom % 3 != 0) consume();
      if ($urandom % 4 == 0) consume();
    end
    while (q_seq.size() > 0) consume();
    chk("R3 wrapped frames seen", int'(n_wrap > 0), 1);
    chk("R7 random overflows seen", int'(n_ovw > 1), 1);
    summary();
  end
endmodule